// File: doc/BRIEF.md
# Variable-Rate DAC Slot Request Generator

This block decides, once per audio frame, whether the codec asks the controller for a new stereo DAC sample pair. A strobe marks each frame. The frame rate is 48 kHz. With variable rate switched off, the block asks for a sample pair in every frame. With variable rate switched on, it keeps a running sum that grows by the programmed sample rate each frame. A request is issued whenever that sum reaches the frame rate. The spacing between requests therefore depends only on the programmed rate and never drifts. One rate value serves both DAC channels.

The decision is shown on the 12-bit slot-request field of the next input frame. The field is active-low: a 0 means "send a sample" and a 1 means "do not send". The codec mode chooses which pair of field bits carries the decision, and every bit the mode does not choose stays 0. A second output, registered one frame later, tells the capture logic whether the PCM data in the matching output frame is to be used or thrown away.

Top module: `vrate_slot_req`

## Requirements
- R1: While reset is held, and after it until the first frame strobe, no request is shown: in mode 0 `slot_req` equals 12'hC00, and `accept_pcm` is 0.
- R2: While `var_rate_en` is 0, every frame strobe produces a request, which corresponds to 48 kHz.
- R3: While `var_rate_en` is 1, each strobe adds the clamped rate to the running sum. When the result is 48000 or more, 48000 is subtracted and a request is issued for that frame. Over N frames starting from a cleared sum, the number of requests is therefore floor(N*rate/48000). Examples: 48000 gives one request per frame, 24000 gives one every second frame, and 44100 gives 22 requests in 24 frames.
- R4: A rate of 8000 gives a request in every sixth frame, and a rate of 9600 gives one in every fifth frame.
- R5: A rate of 8800 gives request spacings of six and five frames that alternate.
- R6: A rate below 4000 acts as 4000 (first request in frame 12), and a rate above 48000 acts as 48000 (a request in every frame).
- R7: The running sum is cleared in any cycle where `rate_wr` is 1, and in any cycle where `var_rate_en` rises.
- R8: Mode 0 and mode 1 put the decision on bits 11 and 10. Mode 2 puts it on bits 7 and 6. Mode 3 puts it on bits 8 and 5. Both bits of the chosen pair are 0 when a request is made and 1 when none is made.
- R9: Every bit of `slot_req` that the current mode does not choose is 0.
- R10: After each frame strobe, `accept_pcm` equals the request decision that was in force before that strobe.
- R11: `accept_pcm` changes only on a cycle that follows a frame strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_stb | input | 1 | One-cycle pulse, once per frame |
| var_rate_en | input | 1 | 1 selects variable rate, 0 requests in every frame |
| rate_wr | input | 1 | One-cycle pulse when a new rate is written; clears the running sum |
| rate_hz | input | 16 | Programmed DAC sample rate in Hz |
| codec_mode | input | 2 | 0 primary, 1 to 3 secondary modes; selects the request bit pair |
| slot_req | output | 12 | Active-low slot-request field for the next input frame |
| accept_pcm | output | 1 | 1 when data in the matching output frame is to be used |

## Verification
The main function is driven with a set of rates, and each one separates a different behaviour. Rates of 8000 and 9600 show that requests come at fixed intervals of six and five frames. A rate of 8800 shows that the leftover sum is carried from one request to the next, which makes the gaps alternate. Rates of 24000 and 44100 test request counts that come from integer division with a remainder. Rates of 0, 4000, 60000 and 48000 reach both clamp limits and the every-frame case. Directed tests then cover the following:
- fixed-rate operation with variable rate off;
- each mode's bit pair, both when a request is made and when none is made;
- clearing of the sum by a rate write and by a rising enable, where the next request has to come a full interval later;
- the one-frame lag of the accept flag.

// File: rtl/vrs_pkg.sv
package vrs_pkg;
    localparam int unsigned FRAME_HZ_DEF = 48000;
    localparam int unsigned MIN_HZ_DEF   = 4000;
    localparam int unsigned RATE_W_DEF   = 16;
    localparam int unsigned REQ_W        = 12;

    typedef enum logic [1:0] {
        MODE_PRI  = 2'd0,
        MODE_SEC1 = 2'd1,
        MODE_SEC2 = 2'd2,
        MODE_SEC3 = 2'd3
    } codec_mode_e;
endpackage

// File: rtl/vrs_rate_clamp.sv
module vrs_rate_clamp #(
    parameter int unsigned RATE_W   = 16,
    parameter int unsigned ACC_W    = 17,
    parameter int unsigned MIN_HZ   = 4000,
    parameter int unsigned FRAME_HZ = 48000
) (
    input  logic [RATE_W-1:0] rate_in,
    output logic [ACC_W-1:0]  rate_out
);
    localparam logic [RATE_W-1:0] LO = RATE_W'(MIN_HZ);
    localparam logic [RATE_W-1:0] HI = RATE_W'(FRAME_HZ);

    always_comb begin
        if (rate_in < LO) begin
            rate_out = ACC_W'(LO);
        end else if (rate_in > HI) begin
            rate_out = ACC_W'(HI);
        end else begin
            rate_out = ACC_W'(rate_in);
        end
    end
endmodule

// File: rtl/vrs_accum.sv
module vrs_accum #(
    parameter int unsigned ACC_W    = 17,
    parameter int unsigned FRAME_HZ = 48000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_stb,
    input  logic             var_rate_en,
    input  logic             rate_wr,
    input  logic [ACC_W-1:0] rate,
    output logic             req,
    output logic             accept,
    output logic [ACC_W-1:0] acc
);
    localparam logic [ACC_W-1:0] FRAME_A = ACC_W'(FRAME_HZ);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             req;
        logic             accept;
        logic             vra;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic             clear;
    logic [ACC_W-1:0] base;
    logic [ACC_W-1:0] sum;

    always_comb begin
        st_d     = st_q;
        st_d.vra = var_rate_en;
        clear    = rate_wr | (var_rate_en & ~st_q.vra);
        base     = clear ? '0 : st_q.acc;
        sum      = base + rate;
        st_d.acc = var_rate_en ? base : '0;
        if (frame_stb) begin
            st_d.accept = st_q.req;
            if (!var_rate_en) begin
                st_d.req = 1'b1;
            end else if (sum >= FRAME_A) begin
                st_d.req = 1'b1;
                st_d.acc = sum - FRAME_A;
            end else begin
                st_d.req = 1'b0;
                st_d.acc = sum;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req    = st_q.req;
    assign accept = st_q.accept;
    assign acc    = st_q.acc;
endmodule

// File: rtl/vrs_req_map.sv
module vrs_req_map
    import vrs_pkg::*;
#(
    parameter int unsigned W = REQ_W
) (
    input  logic        req,
    input  codec_mode_e mode,
    output logic [W-1:0] bits_out
);
    always_comb begin
        bits_out = '0;
        case (mode)
            MODE_PRI, MODE_SEC1: begin
                bits_out[11] = ~req;
                bits_out[10] = ~req;
            end
            MODE_SEC2: begin
                bits_out[7] = ~req;
                bits_out[6] = ~req;
            end
            default: begin
                bits_out[8] = ~req;
                bits_out[5] = ~req;
            end
        endcase
    end
endmodule

// File: rtl/vrate_slot_req.sv
module vrate_slot_req
    import vrs_pkg::*;
#(
    parameter int unsigned RATE_W   = RATE_W_DEF,
    parameter int unsigned FRAME_HZ = FRAME_HZ_DEF,
    parameter int unsigned MIN_HZ   = MIN_HZ_DEF,
    parameter int unsigned ACC_W    = $clog2(2 * FRAME_HZ)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb,
    input  logic              var_rate_en,
    input  logic              rate_wr,
    input  logic [RATE_W-1:0] rate_hz,
    input  logic [1:0]        codec_mode,
    output logic [REQ_W-1:0]  slot_req,
    output logic              accept_pcm
);
    logic [ACC_W-1:0] rate_c;
    logic [ACC_W-1:0] acc_w;
    logic             req_w;

    vrs_rate_clamp #(
        .RATE_W(RATE_W), .ACC_W(ACC_W), .MIN_HZ(MIN_HZ), .FRAME_HZ(FRAME_HZ)
    ) u_clamp (
        .rate_in (rate_hz),
        .rate_out(rate_c)
    );

    vrs_accum #(
        .ACC_W(ACC_W), .FRAME_HZ(FRAME_HZ)
    ) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_stb  (frame_stb),
        .var_rate_en(var_rate_en),
        .rate_wr    (rate_wr),
        .rate       (rate_c),
        .req        (req_w),
        .accept     (accept_pcm),
        .acc        (acc_w)
    );

    vrs_req_map #(
        .W(REQ_W)
    ) u_map (
        .req     (req_w),
        .mode    (codec_mode_e'(codec_mode)),
        .bits_out(slot_req)
    );
endmodule

// File: rtl/vrs_chk.sv
module vrs_chk #(
    parameter int unsigned ACC_W    = 17,
    parameter int unsigned FRAME_HZ = 48000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_stb,
    input logic             var_rate_en,
    input logic [1:0]       codec_mode,
    input logic [11:0]      slot_req,
    input logic             accept_pcm,
    input logic [ACC_W-1:0] acc
);
    logic req_seen;
    logic pair_ok;

    always_comb begin
        case (codec_mode)
            2'd0, 2'd1: begin
                req_seen = ~slot_req[11];
                pair_ok  = slot_req[11] == slot_req[10];
            end
            2'd2: begin
                req_seen = ~slot_req[7];
                pair_ok  = slot_req[7] == slot_req[6];
            end
            default: begin
                req_seen = ~slot_req[8];
                pair_ok  = slot_req[8] == slot_req[5];
            end
        endcase
    end

    AST_PAIR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        pair_ok); // R8
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_req[9] == 1'b0) && (slot_req[4:0] == 5'd0)); // R9
    AST_FIXED_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && !var_rate_en) |=> req_seen); // R2
    AST_ACCEPT_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> (accept_pcm == $past(req_seen))); // R10
    AST_ACCEPT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> $stable(accept_pcm)); // R11
    AST_SUM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        acc < ACC_W'(FRAME_HZ)); // R3
endmodule

bind vrate_slot_req vrs_chk #(.ACC_W(ACC_W), .FRAME_HZ(FRAME_HZ)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_stb  (frame_stb),
    .var_rate_en(var_rate_en),
    .codec_mode (codec_mode),
    .slot_req   (slot_req),
    .accept_pcm (accept_pcm),
    .acc        (acc_w)
);

// File: tb/vrate_slot_req_tb.sv
module vrate_slot_req_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_stb = 1'b0;
    logic        var_rate_en = 1'b0;
    logic        rate_wr = 1'b0;
    logic [15:0] rate_hz = 16'd0;
    logic [1:0]  codec_mode = 2'd0;
    logic [11:0] slot_req;
    logic        accept_pcm;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    localparam int NV = 9;
    localparam int NF = 24;
    localparam logic [15:0] TV_RATE  [NV] = '{16'd8000, 16'd9600, 16'd8800, 16'd48000,
                                             16'd24000, 16'd44100, 16'd0, 16'd60000, 16'd4000};
    localparam int          TV_FIRST [NV] = '{6, 5, 6, 1, 2, 2, 12, 1, 12};
    localparam int          TV_COUNT [NV] = '{4, 4, 4, 24, 12, 22, 2, 24, 2};

    vrate_slot_req u_dut (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .var_rate_en(var_rate_en),
        .rate_wr(rate_wr), .rate_hz(rate_hz), .codec_mode(codec_mode),
        .slot_req(slot_req), .accept_pcm(accept_pcm)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic frame();
        @(negedge clk) frame_stb = 1'b1;
        @(negedge clk) frame_stb = 1'b0;
    endtask

    task automatic write_rate(input logic [15:0] r);
        @(negedge clk) begin rate_hz = r; rate_wr = 1'b1; end
        @(negedge clk) rate_wr = 1'b0;
    endtask

    task automatic frames_to_req(output int n);
        n = 0;
        for (int k = 0; k < 20; k++) begin
            frame();
            n++;
            if (!slot_req[11]) break;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int n;
        bit prev;
        bit r;
        logic [11:0] hold_req;
        logic        hold_acc;
        repeat (3) @(negedge clk);
        check(slot_req == 12'hC00, "R1 reset slot_req", int'(slot_req), 12'hC00);
        check(accept_pcm == 1'b0, "R1 reset accept", int'(accept_pcm), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(slot_req == 12'hC00, "R1 after reset", int'(slot_req), 12'hC00);

        // R2: fixed rate
        for (int f = 1; f <= 4; f++) begin
            frame();
            check(slot_req == 12'h000, "R2 every frame", int'(slot_req), 0);
            if (f >= 2) check(accept_pcm == 1'b1, "R10 accept fixed", int'(accept_pcm), 1);
        end

        // vector table: R3 R4 R5 R6 R10
        var_rate_en = 1'b1;
        for (int i = 0; i < NV; i++) begin
            int first;
            int count;
            int last;
            int gap_prev;
            string tag;
            tag = (i < 2) ? "R4" : (i == 2) ? "R5" : (i < 6) ? "R3" : "R6";
            write_rate(TV_RATE[i]);
            first = 0; count = 0; last = 0; gap_prev = 0; prev = 1'b0;
            for (int f = 1; f <= NF; f++) begin
                frame();
                r = !slot_req[11];
                if (f >= 2) check(accept_pcm == prev, "R10 accept lag", int'(accept_pcm), int'(prev));
                if (r) begin
                    count++;
                    if (first == 0) first = f;
                    if (i == 2 && last != 0) begin
                        check((f - last == 5) || (f - last == 6), "R5 gap range", f - last, 5);
                        if (gap_prev != 0)
                            check((f - last) != gap_prev, "R5 gap alternates", f - last, 11 - gap_prev);
                        gap_prev = f - last;
                    end
                    last = f;
                end
                prev = r;
            end
            check(first == TV_FIRST[i], {tag, " first request"}, first, TV_FIRST[i]);
            check(count == TV_COUNT[i], {tag, " request count"}, count, TV_COUNT[i]);
        end

        // R8 R9: mode mapping, no request then request
        write_rate(16'd8000);
        frame();
        codec_mode = 2'd0; @(negedge clk);
        check(slot_req == 12'hC00, "R8 mode0 idle", int'(slot_req), 12'hC00);
        codec_mode = 2'd1; @(negedge clk);
        check(slot_req == 12'hC00, "R8 mode1 idle", int'(slot_req), 12'hC00);
        codec_mode = 2'd2; @(negedge clk);
        check(slot_req == 12'h0C0, "R8 mode2 idle", int'(slot_req), 12'h0C0);
        codec_mode = 2'd3; @(negedge clk);
        check(slot_req == 12'h120, "R9 mode3 idle", int'(slot_req), 12'h120);
        repeat (5) frame();
        check(slot_req == 12'h000, "R8 mode3 request", int'(slot_req), 0);
        codec_mode = 2'd2; @(negedge clk);
        check(slot_req == 12'h000, "R9 mode2 request", int'(slot_req), 0);
        codec_mode = 2'd0;

        // R11: no change between strobes
        frame();
        hold_req = slot_req;
        hold_acc = accept_pcm;
        rate_hz = 16'd48000;
        repeat (6) @(negedge clk);
        check(slot_req == hold_req, "R11 slot hold", int'(slot_req), int'(hold_req));
        check(accept_pcm == hold_acc, "R11 accept hold", int'(accept_pcm), int'(hold_acc));

        // R7: clear by rate write
        write_rate(16'd8000);
        repeat (3) frame();
        write_rate(16'd8000);
        frames_to_req(n);
        check(n == 6, "R7 clear on write", n, 6);
        // R7: clear by enable rise
        repeat (3) frame();
        @(negedge clk) var_rate_en = 1'b0;
        @(negedge clk) var_rate_en = 1'b1;
        frames_to_req(n);
        check(n == 6, "R7 clear on enable", n, 6);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule